// File: doc/BRIEF.md
# Synchronous Transfer Period Selector

This block converts a negotiated synchronous transfer period into the clock-divider and period-multiplier settings that a bus controller's data-transfer clock needs. A request arrives as a period in 4 ns steps. The block then walks every divider/multiplier pair, one pair per clock, and keeps the pair whose real period is the shortest one still at least as long as the request. The real period is the core clock period times the divider times the multiplier.

Achievable periods lie on the core clock's grid, which is usually not a 4 ns grid, so the result snaps upward and is never faster than what was agreed. With a 12.5 ns core clock, a 48 ns request therefore becomes 50 ns. A fast-timing enable flag comes out alongside the result and is set for periods under 100 ns. If no pair is slow enough, an error flag is raised and the slowest pair is returned.

Each bus target can have its own settings. After negotiation, the current result is written into a 16-entry table under the target ID. When that target is selected or reselected, its entry is read back, so devices of different speeds can share one bus.

Top module: `xps_sel`

## Requirements
- R1: After reset, `done_o` and `err_o` are 0 and `div_code_o`, `mult_o`, `per_o` and `fast_o` are 0. Every table entry holds the slowest setting: divider code 3, multiplier 11, fast flag 0. The load outputs also show that setting.
- R2: `div_code_o` value c means divider c+1, with c from 0 to 3. `mult_o` lies between 4 and 11. `per_o`, in 0.5 ns units, equals CLK_HALF_NS × (c+1) × `mult_o`.
- R3: When `err_o` is 0, `per_o` is at least 8 × `req_per_i`, counted in 0.5 ns units. No divider/multiplier pair gives a period that is also at least the request and shorter than `per_o`.
- R4: When several pairs give the same period, the pair with the smaller divider is reported.
- R5: When every pair is shorter than the request, `err_o` is 1 and the result is divider code 3, multiplier 11.
- R6: `fast_o` is 1 exactly when `per_o` is below 200, which is 100 ns.
- R7: A `start_i` pulse while idle starts a search that ends with `done_o` high for exactly one cycle. The result outputs change only in that cycle and then hold. A `start_i` during a search is ignored.
- R8: A `store_i` strobe writes the current {`div_code_o`, `mult_o`, `fast_o`} into the entry addressed by `store_id_i`.
- R9: A `select_i` strobe places the entry addressed by `select_id_i` on the `ld_*` outputs one cycle later. The outputs then hold until the next select.
- R10: With the default 12.5 ns clock, request 12 (48 ns) yields divider code 0, multiplier 4, period 100 (50 ns). Request 25 (100 ns) yields divider code 0, multiplier 8, period 200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a search (accepted when idle) |
| req_per_i | input | REQ_W | Requested period in 4 ns units |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| err_o | output | 1 | No pair reaches the request |
| div_code_o | output | 2 | Chosen divider code (divider = code + 1) |
| mult_o | output | 4 | Chosen period multiplier (4 to 11) |
| per_o | output | PER_W | Resulting period in 0.5 ns units |
| fast_o | output | 1 | Fast-timing enable (period below 100 ns) |
| store_i | input | 1 | Write current result into the table |
| store_id_i | input | ID_W | Target ID for the write |
| select_i | input | 1 | Load a target's settings |
| select_id_i | input | ID_W | Target ID for the load |
| ld_div_code_o | output | 2 | Loaded divider code |
| ld_mult_o | output | 4 | Loaded multiplier |
| ld_fast_o | output | 1 | Loaded fast-timing flag |

## Verification
The search is tried with several kinds of request.
- Requests of 0, 12 and 25 test the lower grid edge, the 48-to-50 ns snap and the tie between divider 1 × 8 and divider 2 × 4.
- Requests of 137 and 138 sit on each side of the slowest achievable period, which separates a valid result from the error fallback.
- Random requests spread over and beyond the range compare every output field against a bench search. This catches wrong rounding, a wrong tie order or a wrong fast threshold.

Table stores go to random targets, and a final sweep selects every ID. This tells a correct per-ID write apart from aliasing, and reset contents apart from stored ones.

// File: rtl/xps_pkg.sv
// Package: shared constants and types for the transfer period selector.
// Assumes the divider and multiplier ranges below fit their field widths.
package xps_pkg;
    localparam int DIV_W    = 2;
    localparam int DIV_NUM  = 4;
    localparam int MULT_W   = 4;
    localparam int MULT_MIN = 4;
    localparam int MULT_MAX = 11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FIN  = 2'd2
    } xps_state_e;

    typedef struct packed {
        logic [DIV_W-1:0]  div_code;
        logic [MULT_W-1:0] mult;
        logic              fast;
    } xps_set_t;
endpackage

// File: rtl/xps_cand_gen.sv
// Candidate generator: steps through every divider/multiplier pair,
// divider outer and ascending, multiplier inner and ascending.
// Assumes restart and step are never asserted together.
module xps_cand_gen
    import xps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    output logic [DIV_W-1:0]  div_code,
    output logic [MULT_W-1:0] mult,
    output logic              last
);
    localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(DIV_NUM - 1);
    localparam logic [MULT_W-1:0] M_MIN    = MULT_W'(MULT_MIN);
    localparam logic [MULT_W-1:0] M_MAX    = MULT_W'(MULT_MAX);

    // Advance the candidate pair, wrapping the multiplier into the divider.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_code <= '0;
            mult     <= M_MIN;
        end else if (step) begin
            if (mult == M_MAX) begin
                mult     <= M_MIN;
                div_code <= div_code + 1'b1;
            end else begin
                mult <= mult + 1'b1;
            end
        end
    end

    // Flag the final pair of the sweep.
    always_comb begin
        last = (div_code == DIV_LAST) && (mult == M_MAX);
    end
endmodule

// File: rtl/xps_best_track.sv
// Best-candidate tracker: keeps the shortest candidate period that is not
// shorter than the request. A strict comparison keeps the earlier pair
// (smaller divider) on a tie. Assumes candidates come in ascending divider order.
module xps_best_track
    import xps_pkg::*;
#(
    parameter int CMP_W           = 11,
    parameter int FAST_LIMIT_HALF = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              valid,
    input  logic [DIV_W-1:0]  cand_div,
    input  logic [MULT_W-1:0] cand_mult,
    input  logic [CMP_W-1:0]  cand_per,
    input  logic [CMP_W-1:0]  req_half,
    output logic              found,
    output logic [DIV_W-1:0]  best_div,
    output logic [MULT_W-1:0] best_mult,
    output logic [CMP_W-1:0]  best_per,
    output logic              best_fast
);
    logic take;

    // Decide whether the current candidate beats the kept one.
    always_comb begin
        take = valid && (cand_per >= req_half) && (!found || (cand_per < best_per));
    end

    // Hold the winning pair and its derived fast flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            found     <= 1'b0;
            best_div  <= '0;
            best_mult <= '0;
            best_per  <= '0;
            best_fast <= 1'b0;
        end else if (take) begin
            found     <= 1'b1;
            best_div  <= cand_div;
            best_mult <= cand_mult;
            best_per  <= cand_per;
            best_fast <= (cand_per < CMP_W'(FAST_LIMIT_HALF));
        end
    end
endmodule

// File: rtl/xps_target_table.sv
// Per-target settings table: one entry per target ID, written by a strobe
// and read into a registered output by a select strobe.
// Assumes resetting to the slowest setting is safe for any target.
module xps_target_table
    import xps_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_id,
    input  xps_set_t        wr_data,
    input  logic            rd_en,
    input  logic [ID_W-1:0] rd_id,
    output xps_set_t        rd_data
);
    localparam int       NUM_TGT = 1 << ID_W;
    localparam xps_set_t SLOW_SET = '{div_code: DIV_W'(DIV_NUM - 1),
                                      mult:     MULT_W'(MULT_MAX),
                                      fast:     1'b0};

    xps_set_t entries [NUM_TGT];

    // One write-enabled register per target entry.
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_entry
        // Capture the settings when this entry is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[g] <= SLOW_SET;
            end else if (wr_en && (wr_id == ID_W'(g))) begin
                entries[g] <= wr_data;
            end
        end
    end

    // Present the selected entry one cycle after the select strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= SLOW_SET;
        end else if (rd_en) begin
            rd_data <= entries[rd_id];
        end
    end
endmodule

// File: rtl/xps_sel.sv
// Top: synchronous transfer period selector. A start pulse latches the
// request, a sweep evaluates one divider/multiplier pair per clock, and a
// final state publishes the result with a one-cycle done pulse.
// Assumes CLK_HALF_NS is the core clock period in 0.5 ns units.
module xps_sel
    import xps_pkg::*;
#(
    parameter int CLK_HALF_NS     = 25,
    parameter int REQ_W           = 8,
    parameter int ID_W            = 4,
    parameter int FAST_LIMIT_HALF = 200,
    parameter int PER_W           = $clog2(CLK_HALF_NS * DIV_NUM * MULT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REQ_W-1:0]  req_per_i,
    output logic              done_o,
    output logic              err_o,
    output logic [DIV_W-1:0]  div_code_o,
    output logic [MULT_W-1:0] mult_o,
    output logic [PER_W-1:0]  per_o,
    output logic              fast_o,
    input  logic              store_i,
    input  logic [ID_W-1:0]   store_id_i,
    input  logic              select_i,
    input  logic [ID_W-1:0]   select_id_i,
    output logic [DIV_W-1:0]  ld_div_code_o,
    output logic [MULT_W-1:0] ld_mult_o,
    output logic              ld_fast_o
);
    localparam int REQ_HALF_W = REQ_W + 3;
    localparam int CMP_W      = (PER_W > REQ_HALF_W) ? PER_W : REQ_HALF_W;
    localparam int SLOW_PER   = CLK_HALF_NS * DIV_NUM * MULT_MAX;
    localparam bit SLOW_FAST  = SLOW_PER < FAST_LIMIT_HALF;

    xps_state_e        state;
    logic [CMP_W-1:0]  req_half_q;
    logic              launch;
    logic [DIV_W-1:0]  cand_div;
    logic [MULT_W-1:0] cand_mult;
    logic              cand_last;
    logic [CMP_W-1:0]  cand_per;
    logic              found;
    logic [DIV_W-1:0]  best_div;
    logic [MULT_W-1:0] best_mult;
    logic [CMP_W-1:0]  best_per;
    logic              best_fast;
    xps_set_t          cur_set;
    xps_set_t          ld_set;

    // Accept a start only when idle.
    always_comb begin
        launch = (state == ST_IDLE) && start_i;
    end

    // Sequence the search: idle, sweep, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (start_i)   state <= ST_SCAN;
                ST_SCAN: if (cand_last) state <= ST_FIN;
                ST_FIN:                 state <= ST_IDLE;
                default:                state <= ST_IDLE;
            endcase
        end
    end

    // Latch the request converted to 0.5 ns units.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_half_q <= '0;
        end else if (launch) begin
            req_half_q <= CMP_W'({req_per_i, 3'b000});
        end
    end

    xps_cand_gen i_cand_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (launch),
        .step     (state == ST_SCAN),
        .div_code (cand_div),
        .mult     (cand_mult),
        .last     (cand_last)
    );

    // Real period of the current pair: clock x divider x multiplier.
    always_comb begin
        cand_per = CMP_W'(CLK_HALF_NS) * (CMP_W'(cand_div) + CMP_W'(1)) * CMP_W'(cand_mult);
    end

    xps_best_track #(
        .CMP_W           (CMP_W),
        .FAST_LIMIT_HALF (FAST_LIMIT_HALF)
    ) i_best_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (launch),
        .valid     (state == ST_SCAN),
        .cand_div  (cand_div),
        .cand_mult (cand_mult),
        .cand_per  (cand_per),
        .req_half  (req_half_q),
        .found     (found),
        .best_div  (best_div),
        .best_mult (best_mult),
        .best_per  (best_per),
        .best_fast (best_fast)
    );

    // Publish the result, or the slowest pair on error, with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            err_o      <= 1'b0;
            div_code_o <= '0;
            mult_o     <= '0;
            per_o      <= '0;
            fast_o     <= 1'b0;
        end else if (state == ST_FIN) begin
            done_o <= 1'b1;
            err_o  <= !found;
            if (found) begin
                div_code_o <= best_div;
                mult_o     <= best_mult;
                per_o      <= best_per[PER_W-1:0];
                fast_o     <= best_fast;
            end else begin
                div_code_o <= DIV_W'(DIV_NUM - 1);
                mult_o     <= MULT_W'(MULT_MAX);
                per_o      <= PER_W'(SLOW_PER);
                fast_o     <= SLOW_FAST;
            end
        end else begin
            done_o <= 1'b0;
        end
    end

    // Bundle the current result for the table write port.
    always_comb begin
        cur_set = '{div_code: div_code_o, mult: mult_o, fast: fast_o};
    end

    xps_target_table #(
        .ID_W (ID_W)
    ) i_target_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_i),
        .wr_id   (store_id_i),
        .wr_data (cur_set),
        .rd_en   (select_i),
        .rd_id   (select_id_i),
        .rd_data (ld_set)
    );

    // Split the loaded entry onto the load outputs.
    always_comb begin
        ld_div_code_o = ld_set.div_code;
        ld_mult_o     = ld_set.mult;
        ld_fast_o     = ld_set.fast;
    end
endmodule

// File: rtl/xps_checker.sv
// Checker: temporal properties of the selector's published result.
// Attached to every xps_sel instance by the bind below.
module xps_checker
    import xps_pkg::*;
#(
    parameter int CLK_HALF_NS     = 25,
    parameter int FAST_LIMIT_HALF = 200,
    parameter int PER_W           = 11,
    parameter int CMP_W           = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic              err_o,
    input logic [DIV_W-1:0]  div_code_o,
    input logic [MULT_W-1:0] mult_o,
    input logic [PER_W-1:0]  per_o,
    input logic              fast_o,
    input logic [CMP_W-1:0]  req_half_q
);
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(per_o) && $stable(div_code_o) && $stable(mult_o)));

    a_r3_not_faster: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (CMP_W'(per_o) >= req_half_q));

    a_r5_err_slowest: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> ((div_code_o == DIV_W'(DIV_NUM - 1)) && (mult_o == MULT_W'(MULT_MAX))));

    a_r2_product: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (32'(per_o) == CLK_HALF_NS * (32'(div_code_o) + 1) * 32'(mult_o)));

    a_r2_mult_range: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((mult_o >= MULT_W'(MULT_MIN)) && (mult_o <= MULT_W'(MULT_MAX))));

    a_r6_fast: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fast_o == (32'(per_o) < FAST_LIMIT_HALF)));
endmodule

bind xps_sel xps_checker #(
    .CLK_HALF_NS     (CLK_HALF_NS),
    .FAST_LIMIT_HALF (FAST_LIMIT_HALF),
    .PER_W           (PER_W),
    .CMP_W           (CMP_W)
) i_xps_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_o     (done_o),
    .err_o      (err_o),
    .div_code_o (div_code_o),
    .mult_o     (mult_o),
    .per_o      (per_o),
    .fast_o     (fast_o),
    .req_half_q (req_half_q)
);

// File: tb/test_xps_sel.sv
`timescale 1ns/1ps
module test_xps_sel;
    localparam int CLK_HALF = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  req_per_i = '0;
    logic        done_o, err_o, fast_o;
    logic [1:0]  div_code_o;
    logic [3:0]  mult_o;
    logic [10:0] per_o;
    logic        store_i = 1'b0;
    logic [3:0]  store_id_i = '0;
    logic        select_i = 1'b0;
    logic [3:0]  select_id_i = '0;
    logic [1:0]  ld_div_code_o;
    logic [3:0]  ld_mult_o;
    logic        ld_fast_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int shadow [16];

    always #5 clk = ~clk;

    xps_sel i_xps_sel (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_per_i(req_per_i),
        .done_o(done_o), .err_o(err_o), .div_code_o(div_code_o), .mult_o(mult_o),
        .per_o(per_o), .fast_o(fast_o), .store_i(store_i), .store_id_i(store_id_i),
        .select_i(select_i), .select_id_i(select_id_i), .ld_div_code_o(ld_div_code_o),
        .ld_mult_o(ld_mult_o), .ld_fast_o(ld_fast_o)
    );

    task automatic chk(string rq, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // Bench search: shortest period >= request, smaller divider on ties.
    function automatic void ref_calc(input int req, output int dc, output int m,
                                     output int per, output int err);
        int best = -1;
        dc = 3; m = 11; per = CLK_HALF * 4 * 11; err = 1;
        for (int d = 1; d <= 4; d++) begin
            for (int mm = 4; mm <= 11; mm++) begin
                int p = CLK_HALF * d * mm;
                if (p >= req * 8 && (best < 0 || p < best)) begin
                    best = p; dc = d - 1; m = mm; per = p; err = 0;
                end
            end
        end
    endfunction

    task automatic search(int req);
        int dc, m, per, err, waited;
        @(negedge clk);
        start_i = 1'b1; req_per_i = 8'(req);
        @(negedge clk);
        start_i = 1'b0;
        waited = 0;
        while (!done_o && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        ref_calc(req, dc, m, per, err);
        chk("R7 done seen", int'(done_o), 1);
        chk("R5 err", int'(err_o), err);
        chk("R3 div_code", int'(div_code_o), dc);
        chk("R4 mult", int'(mult_o), m);
        chk("R2 period", int'(per_o), per);
        chk("R6 fast", int'(fast_o), (per < 200) ? 1 : 0);
        @(negedge clk);
        chk("R7 done single pulse", int'(done_o), 0);
        chk("R7 result held", int'(per_o), per);
    endtask

    task automatic store(int id);
        @(negedge clk);
        store_i = 1'b1; store_id_i = 4'(id);
        shadow[id] = {div_code_o, mult_o, fast_o};
        @(negedge clk);
        store_i = 1'b0;
    endtask

    task automatic select_chk(int id, string rq);
        @(negedge clk);
        select_i = 1'b1; select_id_i = 4'(id);
        @(negedge clk);
        select_i = 1'b0;
        chk(rq, int'({ld_div_code_o, ld_mult_o, ld_fast_o}), shadow[id]);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int got;
        for (int i = 0; i < 16; i++) shadow[i] = {2'd3, 4'd11, 1'b0};
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", int'(done_o), 0);
        chk("R1 err", int'(err_o), 0);
        chk("R1 per", int'(per_o), 0);
        chk("R1 ld reset value", int'({ld_div_code_o, ld_mult_o, ld_fast_o}), shadow[0]);
        select_chk(7, "R1 table reset entry");
        // R10 directed examples
        search(12);
        chk("R10 48ns period", int'(per_o), 100);
        search(25);
        chk("R10 100ns mult", int'(mult_o), 8);
        search(0);
        search(137);
        search(138);
        chk("R5 err at 138", int'(err_o), 1);
        search(255);
        // R7 start ignored during a search
        @(negedge clk);
        start_i = 1'b1; req_per_i = 8'd12;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        start_i = 1'b1; req_per_i = 8'd25;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        chk("R7 ignored start", int'(per_o), 100);
        got = 0;
        repeat (45) begin
            @(negedge clk);
            if (done_o) got++;
        end
        chk("R7 no second done", got, 0);
        // Random requests plus table stores
        for (int i = 0; i < 50; i++) begin
            int r = (i % 5 == 0) ? int'($urandom_range(255)) : int'($urandom_range(140));
            search(r);
            if ($urandom_range(1) == 1) store(int'($urandom_range(15)));
        end
        store(3);
        select_chk(3, "R8 store then select");
        // R9 sweep every target
        for (int id = 0; id < 16; id++) select_chk(id, "R9 select entry");
        @(negedge clk);
        chk("R9 load held", int'({ld_div_code_o, ld_mult_o, ld_fast_o}), shadow[15]);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule